// File: doc/BRIEF.md
# Single-Lane Flash Command Sequencer

This block sends short, self-contained commands to a serial flash device over one data line. Typical uses are reading a status or identification value, issuing write-enable, or starting an erase. The host describes the whole command in one packed command word: an opcode, plus optional address, write-data, dummy and read-data phases. The length of each phase is stored as the byte count minus one. Writing that word with the execute bit set starts the command. The host then polls the in-progress bit until it clears, and collects up to eight response bytes from two 32-bit result words.

The serial clock itself is generated elsewhere. The sequencer receives a one-cycle strobe (`sclk_en`), and each strobe ends one bit slot. During a bit slot the outgoing bit is held on `fl_mosi`. The incoming bit on `fl_miso` is sampled on the clock edge that ends the slot. `fl_clk` marks every strobe that ends a bit slot, so a device model or clock pad can follow the command.

The sequencer is one state machine with these states: `ST_IDLE`, `ST_START`, `ST_OPCODE`, `ST_ADDR`, `ST_WDATA`, `ST_DUMMY`, `ST_RDATA` and `ST_FINISH`. The transitions are:
- `ST_IDLE` to `ST_START` when an execute write is accepted.
- `ST_START` to `ST_OPCODE` unconditionally.
- From each shifting state, after its last bit slot, to the next enabled phase in the order address, write data, dummy, read data. When no later phase is enabled, the machine goes to `ST_FINISH`.
- `ST_FINISH` to `ST_IDLE` unconditionally.

Top module: `flash_cmd_engine`

## Requirements
- R1: Register writes are selected by `reg_sel`: 0 is the command word, 1 the address, 2 write data for bytes 0..3, and 3 write data for bytes 4..7. The command word fields are:
  - opcode in bits 31:24
  - read enable at bit 23, read byte count minus one in bits 22:20
  - address enable at bit 19, address byte count minus one in bits 17:16
  - write enable at bit 15, write byte count minus one in bits 14:12
  - dummy clock count in bits 11:7
  - execute at bit 0

  `cmd_readback` returns bits 31:2 as written, the in-progress flag at bit 1 and the execute flag at bit 0.
- R2: A command-word write with bit 0 set while idle is accepted. From the next cycle the execute flag reads 1 for exactly one cycle, and the in-progress flag reads 1 until the command ends.
- R3: While in progress, writes to any register have no effect: stored fields, the address and the write data stay unchanged, and the running command is not restarted.
- R4: Phases run in this order: opcode, address, write data, dummy, read data. Disabled phases and a zero dummy count are skipped. `fl_cs_n` is low exactly during the bit slots of the command and high whenever the block is idle.
- R5: The opcode is sent as 8 bits, most-significant bit first.
- R6: The address phase sends the low N bytes of the address register, with N equal to the field plus 1. It goes most-significant byte first and most-significant bit first.
- R7: The write phase sends N bytes, with N equal to the field plus 1. Byte i is bits 8i+7:8i of {high word, low word}, bytes go in increasing order, and each byte goes most-significant bit first.
- R8: During dummy and read slots `fl_mosi` is 0. The dummy phase lasts exactly the programmed number of bit slots.
- R9: The read phase captures N bytes, with N equal to the field plus 1, each most-significant bit first. Byte i is placed in bits 8i+7:8i of {`rdata_hi`, `rdata_lo`}. All result bytes are zero from the start of each command, so bytes not received stay zero.
- R10: A bit slot advances only on a cycle with `sclk_en` high. `fl_clk` is high exactly on those cycles during a shifting phase. The number of `fl_clk` pulses per command is 8 + 8·address bytes + 8·write bytes + dummy + 8·read bytes.
- R11: After reset: `cmd_readback`, `rdata_lo` and `rdata_hi` are 0, and `fl_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for writes |
| reg_wdata | input | 32 | Register write data |
| sclk_en | input | 1 | Serial bit-slot strobe |
| fl_miso | input | 1 | Serial data from the device |
| cmd_readback | output | 32 | Command word with in-progress and execute flags |
| rdata_lo | output | 32 | Response bytes 0..3 |
| rdata_hi | output | 32 | Response bytes 4..7 |
| fl_cs_n | output | 1 | Active-low device select |
| fl_clk | output | 1 | Bit-slot pulse |
| fl_mosi | output | 1 | Serial data to the device |

## Verification
The bench sweeps every address length with and without read phases of every length, under several dummy counts. It then sweeps every write length against every address length, alternating between a strobe every cycle and every other cycle.
- A wrong byte order in the address or write data shows up as a segment of the serial stream that differs from the arithmetically built one.
- A missing clear of the result words leaves stale bytes from the previous, longer read.
- A miscounted phase length shifts every later segment and changes the pulse count.

Targeted cases cover:
- the one-cycle execute flag;
- a rewrite of the command word and the address while busy, which must neither restart the command nor change the address the next command uses;
- a stall with the strobe held low, during which the command must freeze with select still asserted.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    localparam int REG_W   = 32;
    localparam int RESP_W  = 2 * REG_W;
    localparam int LEN_W   = 7;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_WLO  = 2'd2;
    localparam logic [1:0] SEL_WHI  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_OPCODE, ST_ADDR,
        ST_WDATA, ST_DUMMY, ST_RDATA, ST_FINISH
    } fc_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       rd_en;
        logic [2:0] rd_m1;
        logic       addr_en;
        logic [1:0] addr_m1;
        logic       wr_en;
        logic [2:0] wr_m1;
        logic [4:0] dummy;
    } fc_cmd_t;

    function automatic fc_cmd_t decode_cmd(input logic [REG_W-1:0] w);
        fc_cmd_t c;
        c.opcode  = w[31:24];
        c.rd_en   = w[23];
        c.rd_m1   = w[22:20];
        c.addr_en = w[19];
        c.addr_m1 = w[17:16];
        c.wr_en   = w[15];
        c.wr_m1   = w[14:12];
        c.dummy   = w[11:7];
        return c;
    endfunction

    // Next enabled phase after cur; disabled phases are skipped.
    function automatic fc_state_e next_phase(input fc_state_e cur, input fc_cmd_t c);
        if (cur == ST_OPCODE && c.addr_en)
            return ST_ADDR;
        if ((cur == ST_OPCODE || cur == ST_ADDR) && c.wr_en)
            return ST_WDATA;
        if ((cur == ST_OPCODE || cur == ST_ADDR || cur == ST_WDATA) && c.dummy != 5'd0)
            return ST_DUMMY;
        if (cur != ST_RDATA && c.rd_en)
            return ST_RDATA;
        return ST_FINISH;
    endfunction

    // Number of bit slots in a shifting phase.
    function automatic logic [LEN_W-1:0] phase_len(input fc_state_e cur, input fc_cmd_t c);
        logic [2:0] abytes;
        logic [3:0] wbytes;
        logic [3:0] rbytes;
        abytes = {1'b0, c.addr_m1} + 3'd1;
        wbytes = {1'b0, c.wr_m1} + 4'd1;
        rbytes = {1'b0, c.rd_m1} + 4'd1;
        case (cur)
            ST_OPCODE: return 7'd8;
            ST_ADDR:   return {1'b0, abytes, 3'b000};
            ST_WDATA:  return {wbytes, 3'b000};
            ST_DUMMY:  return {2'b00, c.dummy};
            ST_RDATA:  return {rbytes, 3'b000};
            default:   return 7'd1;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_regs.sv
`timescale 1ns/1ps
module flash_cmd_regs
    import flash_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [1:0]           sel_i,
    input  logic [REG_W-1:0]     wdata_i,
    input  logic                 busy_i,
    output logic                 start_o,
    output fc_cmd_t              cmd_o,
    output logic [REG_W-1:0]     addr_o,
    output logic [RESP_W-1:0]    wpay_o,
    output logic [REG_W-1:0]     readback_o
);

    logic [REG_W-1:2] cmd_q;
    logic             exec_q;
    logic [REG_W-1:0] addr_q;
    logic [REG_W-1:0] wlo_q;
    logic [REG_W-1:0] whi_q;
    logic             wr_ok;
    logic             bit1_unused;

    assign bit1_unused = wdata_i[1];
    assign wr_ok       = wr_en_i && !busy_i;
    assign start_o     = wr_ok && (sel_i == SEL_CMD) && wdata_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            exec_q <= 1'b0;
            addr_q <= '0;
            wlo_q  <= '0;
            whi_q  <= '0;
        end else begin
            exec_q <= start_o;
            if (wr_ok) begin
                unique case (sel_i)
                    SEL_CMD:  cmd_q  <= wdata_i[REG_W-1:2];
                    SEL_ADDR: addr_q <= wdata_i;
                    SEL_WLO:  wlo_q  <= wdata_i;
                    SEL_WHI:  whi_q  <= wdata_i;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        cmd_o      = decode_cmd({cmd_q, 2'b00});
        addr_o     = addr_q;
        wpay_o     = {whi_q, wlo_q};
        readback_o = {cmd_q, busy_i, exec_q};
    end

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  fc_cmd_t              cmd_i,
    input  logic [REG_W-1:0]     addr_i,
    input  logic [RESP_W-1:0]    wpay_i,
    input  logic                 sclk_en_i,
    input  logic                 miso_i,
    output logic                 busy_o,
    output logic                 cs_n_o,
    output logic                 fl_clk_o,
    output logic                 mosi_o,
    output logic [RESP_W-1:0]    rdata_o
);

    fc_state_e          state_q, state_d;
    logic [LEN_W-1:0]   cnt_q, cnt_d;
    logic [6:0]         rx_q, rx_d;
    logic [RESP_W-1:0]  rdata_q, rdata_d;
    logic               shifting;
    logic               slot_last;
    logic [4:0]         addr_idx;

    assign shifting  = (state_q == ST_OPCODE) || (state_q == ST_ADDR) ||
                       (state_q == ST_WDATA)  || (state_q == ST_DUMMY) ||
                       (state_q == ST_RDATA);
    assign slot_last = (cnt_q == phase_len(state_q, cmd_i) - 7'd1);
    assign addr_idx  = 5'(({3'd0, cmd_i.addr_m1} + 5'd1) * 5'd8 - 5'd1 - cnt_q[4:0]);

    // Next-state and datapath update
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rx_d    = rx_q;
        rdata_d = rdata_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_START;
                    rdata_d = '0;
                end
            end
            ST_START: begin
                state_d = ST_OPCODE;
                cnt_d   = '0;
            end
            ST_OPCODE, ST_ADDR, ST_WDATA, ST_DUMMY, ST_RDATA: begin
                if (sclk_en_i) begin
                    if (state_q == ST_RDATA) begin
                        rx_d = {rx_q[5:0], miso_i};
                        if (cnt_q[2:0] == 3'd7)
                            rdata_d[{cnt_q[5:3], 3'b000} +: 8] = {rx_q, miso_i};
                    end
                    if (slot_last) begin
                        state_d = next_phase(state_q, cmd_i);
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_q + 7'd1;
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rx_q    <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rx_q    <= rx_d;
            rdata_q <= rdata_d;
        end
    end

    // Outputs
    always_comb begin
        busy_o   = (state_q != ST_IDLE);
        cs_n_o   = !shifting;
        fl_clk_o = shifting && sclk_en_i;
        rdata_o  = rdata_q;
        mosi_o   = 1'b0;
        case (state_q)
            ST_OPCODE: mosi_o = cmd_i.opcode[~cnt_q[2:0]];
            ST_ADDR:   mosi_o = addr_i[addr_idx];
            ST_WDATA:  mosi_o = wpay_i[{cnt_q[5:3], ~cnt_q[2:0]}];
            default:   mosi_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_cmd_engine.sv
`timescale 1ns/1ps
module flash_cmd_engine
    import flash_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        sclk_en,
    input  logic        fl_miso,
    output logic [31:0] cmd_readback,
    output logic [31:0] rdata_lo,
    output logic [31:0] rdata_hi,
    output logic        fl_cs_n,
    output logic        fl_clk,
    output logic        fl_mosi
);

    logic               start;
    logic               busy;
    fc_cmd_t            cmd;
    logic [REG_W-1:0]   addr;
    logic [RESP_W-1:0]  wpay;
    logic [RESP_W-1:0]  rdata;

    flash_cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr_en),
        .sel_i      (reg_sel),
        .wdata_i    (reg_wdata),
        .busy_i     (busy),
        .start_o    (start),
        .cmd_o      (cmd),
        .addr_o     (addr),
        .wpay_o     (wpay),
        .readback_o (cmd_readback)
    );

    flash_cmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .cmd_i     (cmd),
        .addr_i    (addr),
        .wpay_i    (wpay),
        .sclk_en_i (sclk_en),
        .miso_i    (fl_miso),
        .busy_o    (busy),
        .cs_n_o    (fl_cs_n),
        .fl_clk_o  (fl_clk),
        .mosi_o    (fl_mosi),
        .rdata_o   (rdata)
    );

    assign rdata_lo = rdata[REG_W-1:0];
    assign rdata_hi = rdata[RESP_W-1:REG_W];

endmodule

// File: rtl/flash_cmd_engine_chk.sv
`timescale 1ns/1ps
module flash_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sclk_en,
    input logic [31:0] cmd_readback,
    input logic        fl_cs_n,
    input logic        fl_clk
);

    // R4
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_cs_n |-> cmd_readback[1]);

    // R2
    exec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_readback[0] |=> !cmd_readback[0]);

    // R2
    exec_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_readback[0] |-> cmd_readback[1]);

    // R10
    clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_clk |-> (sclk_en && !fl_cs_n));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_readback[1] && $past(cmd_readback[1])) |-> $stable(cmd_readback[31:2]));

endmodule

bind flash_cmd_engine flash_cmd_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_en      (sclk_en),
    .cmd_readback (cmd_readback),
    .fl_cs_n      (fl_cs_n),
    .fl_clk       (fl_clk)
);

// File: tb/flash_cmd_engine_test.sv
`timescale 1ns/1ps
module flash_cmd_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        sclk_en = 1'b0;
    logic        fl_miso = 1'b0;
    logic [31:0] cmd_readback;
    logic [31:0] rdata_lo;
    logic [31:0] rdata_hi;
    logic        fl_cs_n;
    logic        fl_clk;
    logic        fl_mosi;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_n = 0;
    int en_div = 1;
    bit en_hold = 1'b0;
    int pulse_cnt = 0;
    int rd_start = 1000;
    logic [255:0] got_bits;
    logic [7:0]   resp_q [8];
    logic [31:0]  cur_addr = 32'd0;

    always #2.5 clk = ~clk;

    flash_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .sclk_en(sclk_en), .fl_miso(fl_miso),
        .cmd_readback(cmd_readback), .rdata_lo(rdata_lo), .rdata_hi(rdata_hi),
        .fl_cs_n(fl_cs_n), .fl_clk(fl_clk), .fl_mosi(fl_mosi)
    );

    // strobe generator
    always @(negedge clk) begin
        cyc_n++;
        sclk_en = !en_hold && ((cyc_n % en_div) == 0);
    end

    // device model: records outgoing bits, drives response bits
    always @(negedge clk) begin
        #1;
        if (fl_clk) begin
            int q;
            got_bits[pulse_cnt] = fl_mosi;
            if (pulse_cnt >= rd_start) begin
                q = pulse_cnt - rd_start;
                fl_miso = resp_q[q / 8][7 - (q % 8)];
            end else begin
                fl_miso = 1'b0;
            end
            pulse_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_sel   = sel;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input logic [7:0] op, input int an, input int wn,
                                           input int dn, input int rn, input bit ex);
        logic [31:0] w;
        w = 32'd0;
        w[31:24] = op;
        w[23]    = (rn > 0);
        w[22:20] = 3'(rn - 1);
        w[19]    = (an > 0);
        w[17:16] = 2'(an - 1);
        w[15]    = (wn > 0);
        w[14:12] = 3'(wn - 1);
        w[11:7]  = 5'(dn);
        w[0]     = ex;
        return w;
    endfunction

    // packs len bits starting at off, first bit at the MSB
    function automatic logic [63:0] seg(input int off, input int len);
        logic [63:0] v;
        v = 64'd0;
        for (int k = 0; k < len; k++) v = {v[62:0], got_bits[off + k]};
        return v;
    endfunction

    task automatic wait_idle();
        int guard;
        guard = 0;
        do begin
            @(negedge clk);
            #2;
            guard++;
        end while (cmd_readback[1] && guard < 3000);
        check(!cmd_readback[1], "R2 command never completed", {63'd0, cmd_readback[1]}, 64'd0);
    endtask

    // Issue one command and check every segment of it.
    task automatic run_cmd(input logic [7:0] op, input int an, input int wn, input int dn,
                           input int rn, input logic [31:0] av, input logic [63:0] wv,
                           input int seed, input bit load_addr);
        int o_w, o_d, o_r, total;
        logic [63:0] ew, er;
        if (load_addr) begin
            wr_reg(2'd1, av);
            cur_addr = av;
        end
        wr_reg(2'd2, wv[31:0]);
        wr_reg(2'd3, wv[63:32]);
        wr_reg(2'd0, mk_cmd(op, an, wn, dn, rn, 1'b0));
        o_w   = 8 + 8 * an;
        o_d   = o_w + 8 * wn;
        o_r   = o_d + dn;
        total = o_r + 8 * rn;
        for (int i = 0; i < 8; i++) resp_q[i] = 8'(seed * 37 + i * 91 + 5);
        pulse_cnt = 0;
        rd_start  = o_r;
        wr_reg(2'd0, mk_cmd(op, an, wn, dn, rn, 1'b1));
        wait_idle();
        check(pulse_cnt == total, "R10 pulse count", 64'(pulse_cnt), 64'(total));
        check(fl_cs_n == 1'b1, "R4 select released", {63'd0, fl_cs_n}, 64'd1);
        check(seg(0, 8) == {56'd0, op}, "R5 opcode bits", seg(0, 8), {56'd0, op});
        if (an > 0)
            check(seg(8, 8 * an) == 64'(cur_addr & (32'hFFFF_FFFF >> (32 - 8 * an))),
                  "R6 address bits", seg(8, 8 * an),
                  64'(cur_addr & (32'hFFFF_FFFF >> (32 - 8 * an))));
        if (wn > 0) begin
            ew = 64'd0;
            for (int i = 0; i < wn; i++) ew = {ew[55:0], wv[8 * i +: 8]};
            check(seg(o_w, 8 * wn) == ew, "R7 write data bits", seg(o_w, 8 * wn), ew);
        end
        if (dn > 0 || rn > 0) begin
            int zero_ok;
            zero_ok = 1;
            for (int k = o_d; k < total; k++) if (got_bits[k] !== 1'b0) zero_ok = 0;
            check(zero_ok == 1, "R8 quiet line in dummy/read", 64'(zero_ok), 64'd1);
        end
        er = 64'd0;
        for (int i = 0; i < rn; i++) er[8 * i +: 8] = resp_q[i];
        check(rdata_lo == er[31:0], "R9 response low word", {32'd0, rdata_lo}, {32'd0, er[31:0]});
        check(rdata_hi == er[63:32], "R9 response high word", {32'd0, rdata_hi}, {32'd0, er[63:32]});
        check(cmd_readback[31:2] == mk_cmd(op, an, wn, dn, rn, 1'b0) >> 2, "R1 command readback",
              {32'd0, cmd_readback}, {32'd0, mk_cmd(op, an, wn, dn, rn, 1'b0)});
        check(cmd_readback[0] == 1'b0, "R2 execute flag cleared", {63'd0, cmd_readback[0]}, 64'd0);
    endtask

    initial begin
        #950000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int idx;
        repeat (4) @(negedge clk);
        #2;
        // R11 reset state
        check(cmd_readback == 32'd0, "R11 readback after reset", {32'd0, cmd_readback}, 64'd0);
        check({rdata_hi, rdata_lo} == 64'd0, "R11 result after reset", {rdata_hi, rdata_lo}, 64'd0);
        check(fl_cs_n == 1'b1, "R11 select after reset", {63'd0, fl_cs_n}, 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: execute flag for one cycle, in-progress held
        en_div = 1;
        wr_reg(2'd1, 32'h00A1_B2C3);
        cur_addr = 32'h00A1_B2C3;
        pulse_cnt = 0;
        rd_start  = 8 + 24 + 5;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = mk_cmd(8'h0B, 3, 0, 5, 8, 1'b1);
        @(negedge clk);
        reg_wr_en = 1'b0;
        #2;
        check(cmd_readback[1:0] == 2'b11, "R2 flags after accept", {62'd0, cmd_readback[1:0]}, 64'd3);
        @(negedge clk);
        #2;
        check(cmd_readback[1:0] == 2'b10, "R2 flags one cycle later", {62'd0, cmd_readback[1:0]}, 64'd2);
        // R3: rewrites while busy are ignored
        wr_reg(2'd0, mk_cmd(8'h9F, 0, 0, 0, 1, 1'b1));
        wr_reg(2'd1, 32'h5555_5555);
        #2;
        check(cmd_readback[31:24] == 8'h0B, "R3 opcode held while busy",
              {56'd0, cmd_readback[31:24]}, 64'h0B);
        wait_idle();
        check(pulse_cnt == 8 + 24 + 5 + 64, "R3 no restart", 64'(pulse_cnt), 64'(8 + 24 + 5 + 64));
        // R3: address register unchanged, seen through the next command
        run_cmd(8'h20, 3, 0, 0, 0, 32'd0, 64'd0, 1, 1'b0);

        // R10: stall with strobe held low
        en_hold = 1'b1;
        pulse_cnt = 0;
        rd_start  = 8;
        wr_reg(2'd0, mk_cmd(8'h05, 0, 0, 0, 1, 1'b1));
        repeat (20) @(negedge clk);
        #2;
        check(pulse_cnt == 0, "R10 no pulses without strobe", 64'(pulse_cnt), 64'd0);
        check(cmd_readback[1] == 1'b1, "R10 still in progress", {63'd0, cmd_readback[1]}, 64'd1);
        check(fl_cs_n == 1'b0, "R4 select held during stall", {63'd0, fl_cs_n}, 64'd0);
        en_hold = 1'b0;
        wait_idle();
        check(pulse_cnt == 16, "R10 stalled command length", 64'(pulse_cnt), 64'd16);

        // Sweep read and address lengths with dummy counts
        idx = 0;
        for (int ri = 0; ri <= 8; ri++) begin
            for (int ai = 0; ai <= 4; ai++) begin
                for (int di = 0; di < 3; di++) begin
                    int dn;
                    dn = (di == 0) ? 0 : ((di == 1) ? 3 : 31);
                    en_div = (idx % 2) + 1;
                    run_cmd(8'(idx * 13 + 3), ai, 0, dn, ri, 32'(idx * 32'h0103_0507 + 32'h89AB_CDEF),
                            64'd0, idx, 1'b1);
                    idx++;
                end
            end
        end
        // Sweep write and address lengths
        for (int wi = 1; wi <= 8; wi++) begin
            for (int ai = 0; ai <= 4; ai++) begin
                en_div = (idx % 2) + 1;
                run_cmd(8'(idx * 7 + 1), ai, wi, 8, 4, 32'(idx * 32'h1357_9BDF),
                        {32'(idx * 32'h2468_ACE1), 32'(idx * 32'hF0E1_D2C3 + 32'h0102_0304)},
                        idx, 1'b1);
                idx++;
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule